// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer with its own clock divider and a 12-bit down-counter. Software controls it through four write-only registers (a key register, a divider-select register, a reload register and a window register) using a single-cycle write strobe. All control actions are issued by writing a code word to the key register. These actions are starting the timer, refreshing the counter, and opening or closing write access to the three configuration registers.

Once started, the timer cannot be stopped. The counter drops by one on every divided tick. A tick that finds the counter at zero raises a one-cycle system reset request, and the counter then restarts from the reload value. A window value lets the block also reject refreshes that come too early. A refresh made while the counter is still above the window raises the reset request at once instead of reloading the counter.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is stopped, `cntValue` is 12'hFFF and `rstReq` is low. The reload value is 12'hFFF, the divider code is 0, configuration is locked, and the window is 12'hFFF, so no refresh is ever early.
- R2: A write is taken on a clock edge where `wrEn` is high, and `wrSel` picks the target. The codes are 0 for the key register, 1 for the divider code (`wrData[2:0]`), 2 for the reload value (`wrData[11:0]`) and 3 for the window value (`wrData[11:0]`).
- R3: Key 16'hCCCC written while the timer is stopped sets `running` after that edge, loads the counter with the reload value and restarts the divider. The same key written while the timer is running has no effect.
- R4: Divider codes 0 to 6 give one tick every 4, 8, 16, 32, 64, 128 and 256 clock cycles. Code 7 also gives 256.
- R5: While running, each tick lowers the counter by one. A tick that finds the counter at zero raises `rstReq` for one cycle and reloads the counter. After start or an accepted refresh with reload value R and period P, the next request comes (R+1)*P cycles later, and further requests follow at the same period.
- R6: Key 16'hAAAA reloads the counter from the reload value and restarts the divider, unless R9 applies. Every such key write also locks configuration.
- R7: Key 16'h5555 unlocks the divider, reload and window registers, and key 16'h0000 locks them. Writes to these registers while they are locked are ignored.
- R8: A key write with any value not listed in R3, R6 and R7 changes nothing.
- R9: A refresh key written while running, when the counter is above the window value, raises `rstReq` after that edge and leaves the counter to count on without reloading.
- R10: No key value stops the timer. `running` stays high until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle write strobe |
| wrSel | input | 2 | Target register select (R2) |
| wrData | input | 16 | Write data |
| running | output | 1 | Timer has been started |
| cntValue | output | 12 | Current down-counter value |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
A wrong divider phase or terminal value shows up as a counter step a few cycles early or late. The first such step appears at most one tick period after the fault, and the request interval drifts accordingly. A lock flag stuck open or closed only becomes visible at the next refresh, when the counter loads a reload value it should not have, or fails to load one it should have. A window comparison of the wrong polarity shows as a missing or spurious request on the edge right after the refresh. The bench therefore compares the counter, the running flag and the request line against a behavioural model on every cycle, and it also measures whole expiry intervals.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W      = 12;
  localparam int KEY_W      = 16;
  localparam int PSC_W      = 3;
  localparam int SEL_W      = 2;
  localparam int BASE_SHIFT = 2;   // smallest division is 2**BASE_SHIFT
  localparam int MAX_CODE   = 6;   // codes above this saturate
  localparam int DIV_W      = BASE_SHIFT + MAX_CODE;

  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_LOCK    = 16'h0000;

  typedef enum logic [SEL_W-1:0] {
    SEL_KEY = 2'd0,
    SEL_PSC = 2'd1,
    SEL_RLD = 2'd2,
    SEL_WIN = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic refresh;
  } wdgStb_t;
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int KW = KEY_W,
  parameter int PW = PSC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [KW-1:0] wrData,
  output wdgStb_t       stb,
  output logic          running,
  output logic          unlocked,
  output logic [PW-1:0] pscCode,
  output logic [CW-1:0] rldVal,
  output logic [CW-1:0] winVal
);
  regSel_e sel;
  logic    keyWr;

  always_comb begin
    sel         = regSel_e'(wrSel);
    keyWr       = wrEn && (sel == SEL_KEY);
    stb.start   = keyWr && (wrData == KEY_START) && !running;
    stb.refresh = keyWr && (wrData == KEY_REFRESH);
  end

  // run flag: set once, cleared only by reset
  always_ff @(posedge clk) begin
    if (!rst_n) running <= 1'b0;
    else if (stb.start) running <= 1'b1;
  end

  // lock state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (keyWr) begin
      case (wrData)
        KEY_UNLOCK:            unlocked <= 1'b1;
        KEY_LOCK, KEY_REFRESH: unlocked <= 1'b0;
        default:               unlocked <= unlocked;
      endcase
    end
  end

  // protected configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pscCode <= '0;
      rldVal  <= '1;
      winVal  <= '1;
    end else if (wrEn && unlocked) begin
      case (sel)
        SEL_PSC: pscCode <= wrData[PW-1:0];
        SEL_RLD: rldVal  <= wrData[CW-1:0];
        SEL_WIN: winVal  <= wrData[CW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
  import wdg_pkg::*;
#(
  parameter int PW    = PSC_W,
  parameter int SHIFT = BASE_SHIFT,
  parameter int TOP   = MAX_CODE,
  localparam int DW   = SHIFT + TOP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          clear,
  input  logic [PW-1:0] code,
  output logic          tick
);
  logic [DW-1:0] divCnt;
  logic [DW-1:0] term;

  // terminal count = 2**(SHIFT+min(code,TOP)) - 1
  always_comb begin
    term = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < SHIFT + ((int'(code) > TOP) ? TOP : int'(code))) term[i] = 1'b1;
    end
    tick = enable && (divCnt >= term);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                divCnt <= '0;
    else if (clear || !enable) divCnt <= '0;
    else if (tick)             divCnt <= '0;
    else                       divCnt <= divCnt + 1'b1;
  end
endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PSC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wdgStb_t       stb,
  input  logic          running,
  input  logic [PW-1:0] pscCode,
  input  logic [CW-1:0] rldVal,
  input  logic [CW-1:0] winVal,
  output logic [CW-1:0] cntValue,
  output logic          rstReq
);
  logic tick;
  logic early;
  logic loadCnt;

  always_comb begin
    early   = stb.refresh && running && (cntValue > winVal);
    loadCnt = stb.start || (stb.refresh && !early);
  end

  wdg_prescaler #(.PW(PW)) uDiv (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (running),
    .clear  (loadCnt),
    .code   (pscCode),
    .tick   (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntValue <= '1;
      rstReq   <= 1'b0;
    end else begin
      rstReq <= early || (tick && (cntValue == '0) && !loadCnt);
      if (loadCnt)   cntValue <= rldVal;
      else if (tick) cntValue <= (cntValue == '0) ? rldVal : cntValue - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int KW = KEY_W,
  parameter int PW = PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [KW-1:0]    wrData,
  output logic             running,
  output logic [CW-1:0]    cntValue,
  output logic             rstReq
);
  wdgStb_t       stb;
  logic          unlocked;
  logic [PW-1:0] pscCode;
  logic [CW-1:0] rldVal;
  logic [CW-1:0] winVal;

  wdg_ctrl #(.CW(CW), .KW(KW), .PW(PW)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .stb      (stb),
    .running  (running),
    .unlocked (unlocked),
    .pscCode  (pscCode),
    .rldVal   (rldVal),
    .winVal   (winVal)
  );

  wdg_datapath #(.CW(CW), .PW(PW)) uData (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .running  (running),
    .pscCode  (pscCode),
    .rldVal   (rldVal),
    .winVal   (winVal),
    .cntValue (cntValue),
    .rstReq   (rstReq)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wrEn,
  input logic [SEL_W-1:0] wrSel,
  input logic [KEY_W-1:0] wrData,
  input logic             running,
  input logic [CNT_W-1:0] cntValue,
  input logic             rstReq,
  input logic             unlocked,
  input logic [CNT_W-1:0] rldVal,
  input logic [CNT_W-1:0] winVal
);
  logic refreshWr;
  assign refreshWr = wrEn && (wrSel == 2'd0) && (wrData == 16'hAAAA);

  // R10
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  // R5
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |-> $past(running));

  // R5
  count_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !refreshWr && cntValue != '0) |=> cntValue <= $past(cntValue));

  // R7
  locked_rld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wrEn && wrSel == 2'd2) |=> $stable(rldVal));

  // R7
  locked_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wrEn && wrSel == 2'd3) |=> $stable(winVal));

  // R6
  refresh_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refreshWr |=> !unlocked);

  // R6
  refresh_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refreshWr && running && cntValue <= winVal) |=> (cntValue == $past(rldVal)) && !rstReq);

  // R9
  early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refreshWr && running && cntValue > winVal) |=> rstReq);
endmodule

bind keyed_watchdog wdg_checker uChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .running  (running),
  .cntValue (cntValue),
  .rstReq   (rstReq),
  .unlocked (unlocked),
  .rldVal   (rldVal),
  .winVal   (winVal)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        running;
  logic [11:0] cntValue;
  logic        rstReq;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  keyed_watchdog dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .running(running), .cntValue(cntValue), .rstReq(rstReq)
  );

  // behavioural reference
  int mRun, mUnl, mPsc, mRld, mWin, mCnt, mDiv, mReq;
  always @(posedge clk) begin
    int period, nCnt, nDiv;
    bit isKey, start, refr, tick, early, load;
    if (!rst_n) begin
      mRun = 0; mUnl = 0; mPsc = 0; mRld = 4095; mWin = 4095;
      mCnt = 4095; mDiv = 0; mReq = 0;
    end else begin
      isKey  = wrEn && wrSel == 2'd0;
      start  = isKey && wrData == 16'hCCCC && mRun == 0;
      refr   = isKey && wrData == 16'hAAAA;
      period = (mPsc >= 6) ? 256 : (4 << mPsc);
      tick   = mRun != 0 && mDiv >= period - 1;
      early  = refr && mRun != 0 && mCnt > mWin;
      load   = start || (refr && !early);
      mReq   = (early || (tick && mCnt == 0 && !load)) ? 1 : 0;
      nCnt = mCnt;
      if (load) nCnt = mRld;
      else if (tick) nCnt = (mCnt == 0) ? mRld : mCnt - 1;
      nDiv = (load || mRun == 0 || tick) ? 0 : mDiv + 1;
      if (wrEn && mUnl != 0) begin
        if (wrSel == 2'd1) mPsc = wrData[2:0];
        if (wrSel == 2'd2) mRld = wrData[11:0];
        if (wrSel == 2'd3) mWin = wrData[11:0];
      end
      if (isKey && wrData == 16'h5555) mUnl = 1;
      if (isKey && (wrData == 16'h0000 || wrData == 16'hAAAA)) mUnl = 0;
      if (start) mRun = 1;
      mCnt = nCnt; mDiv = nDiv;
    end
  end

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cycle compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 cnt", int'(cntValue), mCnt);
      check("R5 req", int'(rstReq), mReq);
      check("R10 run", int'(running), mRun);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitReq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rstReq && n < 5000);
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 running", int'(running), 0);
    check("R1 cnt", int'(cntValue), 4095);
    check("R1 req", int'(rstReq), 0);

    // R7 locked reload write ignored; refresh shows default reload (R1)
    wr(2'd2, 16'd10);
    wr(2'd0, 16'hAAAA);
    check("R7 locked reload", int'(cntValue), 4095);

    // R2 R6 unlocked reload, then refresh locks
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'hAAAA);
    check("R6 refresh load", int'(cntValue), 5);
    wr(2'd2, 16'd9);
    wr(2'd0, 16'hAAAA);
    check("R6 relock", int'(cntValue), 5);

    // R8 unlisted key keeps unlock and does not start
    wr(2'd0, 16'h5555);
    wr(2'd0, 16'h1234);
    check("R8 no start", int'(running), 0);
    wr(2'd2, 16'd7);
    wr(2'd0, 16'hAAAA);
    check("R8 still unlocked", int'(cntValue), 7);

    // R3 start
    wr(2'd0, 16'hCCCC);
    check("R3 running", int'(running), 1);
    check("R3 load", int'(cntValue), 7);
    waitReq(n);
    check("R5 first expiry", n, 8 * 4);
    check("R5 reload after", int'(cntValue), 7);
    waitReq(n);
    check("R5 periodic", n, 8 * 4);

    // R10 lock and repeated start do not stop
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'h5555);
    check("R10 sticky", int'(running), 1);

    // R4 divider codes
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'hAAAA);
    waitReq(n);
    check("R4 code2", n, 4 * 16);
    waitReq(n);
    check("R4 code2 repeat", n, 4 * 16);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd7);
    wr(2'd0, 16'hAAAA);
    waitReq(n);
    check("R4 code7", n, 4 * 256);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd6);
    wr(2'd0, 16'hAAAA);
    waitReq(n);
    check("R4 code6", n, 4 * 256);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd6);
    wr(2'd0, 16'hAAAA);
    check("R6 running refresh", int'(cntValue), 6);

    // R9 window
    wr(2'd0, 16'h5555);
    wr(2'd3, 16'd2);
    wr(2'd0, 16'hAAAA);
    check("R9 early req", int'(rstReq), 1);
    while (cntValue != 12'd2) @(negedge clk);
    wr(2'd0, 16'hAAAA);
    check("R9 in window no req", int'(rstReq), 0);
    check("R9 in window load", int'(cntValue), 6);

    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule